// File: doc/BRIEF.md
# Register Rename and Reorder Buffer

This block sits between decode and a single external ALU in a small out-of-order core that runs ALU operations only. Each decoded operation (opcode, two source register numbers, one destination register number) is accepted at the reorder buffer tail. Its destination is renamed to that slot's tag. Each source is resolved to a ready value or to the tag of the slot that will produce it. The block chooses one operand-complete operation per cycle for the ALU. It watches one result bus (tag plus value) to mark operations complete and to wake operands that wait on them. Completed operations leave from the head in program order and update the architectural register file.

Dispatch and issue are valid/ready streams. A dispatch is accepted on a cycle where both `disp_valid` and `disp_ready` are high. `disp_ready` depends only on buffer occupancy and `flush`, never on `disp_valid`, so the producer may hold an operation for as long as it likes. An issue transfers when `iss_valid` and `iss_ready` are both high. Withholding `iss_ready` leaves the selected operation in place, and it is offered again, still oldest-first. The result bus and the retire outputs are plain strobes with no back-pressure: a result presented is always taken, and a retirement always completes.

`flush` throws away every in-flight operation in one cycle and makes every register read from the architectural file again. The architectural file is kept.

Top module: `rob_rename`

## Requirements
- R1: After reset the buffer is empty, `disp_ready` is 1, `iss_valid` and `ret_valid` are 0, every architectural register holds 0, and every register reads from the architectural file.
- R2: `disp_ready` is 1 exactly when fewer than 8 operations are in flight and `flush` is low. An accepted operation takes the slot at the tail, and the tail advances by one.
- R3: A source register with no in-flight writer takes its value from the architectural file at dispatch.
- R4: A source register with an in-flight writer is resolved in this order: the writer's result if it has already completed; the result-bus value if the writer's tag is on the bus in that same cycle; otherwise the operand waits and captures the bus value the first time its tag appears.
- R5: An entry is eligible when both operands are valid and it has not yet been issued. `iss_valid` offers the eligible entry nearest the head. An offered entry is issued on `iss_valid && iss_ready` and is never offered again.
- R6: When `res_valid` is high, the entry named by `res_tag` is marked complete and holds `res_value` as its result.
- R7: When the head entry is complete, `ret_valid` is high with `ret_reg` and `ret_value` taken from it. On that edge the architectural register is written and the head advances. Operations retire one per cycle, in dispatch order.
- R8: Dispatch renames the destination to the new slot. At retirement the register goes back to reading the architectural file only if its rename still names the retiring slot, so a younger writer of the same register stays visible to later readers.
- R9: `flush` empties the buffer (tail set to head) and makes all registers read from the architectural file. In the flush cycle no dispatch, issue or retirement takes place and the result bus is ignored. The architectural values are kept.
- R10: Every register that is renamed points to an occupied slot between head (inclusive) and tail (exclusive), and that slot's destination equals the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all in-flight operations |
| disp_valid | input | 1 | Dispatch operation present |
| disp_ready | output | 1 | Dispatch can be accepted |
| disp_op | input | 4 | Opcode |
| disp_src_a | input | 3 | First source register |
| disp_src_b | input | 3 | Second source register |
| disp_dst | input | 3 | Destination register |
| iss_valid | output | 1 | An operation is offered to the ALU |
| iss_ready | input | 1 | ALU accepts the offered operation |
| iss_tag | output | 3 | Slot tag of the offered operation |
| iss_op | output | 4 | Opcode of the offered operation |
| iss_opnd_a | output | 16 | First operand value |
| iss_opnd_b | output | 16 | Second operand value |
| res_valid | input | 1 | Result bus strobe |
| res_tag | input | 3 | Slot tag of the result |
| res_value | input | 16 | Result value |
| ret_valid | output | 1 | Head operation retires this cycle |
| ret_reg | output | 3 | Register written by the retiring operation |
| ret_value | output | 16 | Value written by the retiring operation |

## Verification
The hardest situation to reach from the ports is a consumer being dispatched in exactly the cycle its producer's result is on the bus. The result has not yet been latched into the producer's slot, and the consumer has not yet latched its operand. The bench holds the result back, issues the producer alone, and then forces that single pending result onto the bus in the same cycle as the consumer's dispatch. A similar directed sequence retires an older writer of a register while a younger writer of the same register is still in flight. Long random runs with occasional flushes then compare every issued operand and every retired value with an in-order model.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int RR_DEPTH = 8;
  localparam int RR_NREG  = 8;
  localparam int RR_DW    = 16;
  localparam int RR_OPW   = 4;

  typedef enum logic [1:0] {
    SRC_ARCH = 2'd0,
    SRC_ROB  = 2'd1,
    SRC_BUS  = 2'd2,
    SRC_WAIT = 2'd3
  } rr_src_e;
endpackage

// File: rtl/rr_src_resolve.sv
module rr_src_resolve
  import rr_pkg::*;
#(
  parameter int DW = RR_DW,
  parameter int TW = 3
) (
  input  logic          rn_ok,
  input  logic [TW-1:0] rn_tag,
  input  logic [DW-1:0] arch_val,
  input  logic          prod_done,
  input  logic [DW-1:0] prod_res,
  input  logic          bus_valid,
  input  logic [TW-1:0] bus_tag,
  input  logic [DW-1:0] bus_value,
  output logic          op_ok,
  output logic [DW-1:0] op_val,
  output logic [TW-1:0] op_tag
);
  rr_src_e sel;

  always_comb begin
    if (rn_ok)                            sel = SRC_ARCH;
    else if (prod_done)                   sel = SRC_ROB;
    else if (bus_valid && bus_tag == rn_tag) sel = SRC_BUS;
    else                                  sel = SRC_WAIT;
    op_tag = rn_tag;
    op_ok  = (sel != SRC_WAIT);
    unique case (sel)
      SRC_ARCH: op_val = arch_val;
      SRC_ROB:  op_val = prod_res;
      SRC_BUS:  op_val = bus_value;
      default:  op_val = '0;
    endcase
  end
endmodule

// File: rtl/rr_rename_table.sv
module rr_rename_table #(
  parameter int NREG = 8,
  parameter int TW   = 3,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            set_en,
  input  logic [RW-1:0]   set_reg,
  input  logic [TW-1:0]   set_tag,
  input  logic            clr_en,
  input  logic [RW-1:0]   clr_reg,
  input  logic [TW-1:0]   clr_tag,
  output logic [NREG-1:0] rn_valid,
  output logic [TW-1:0]   rn_tag [NREG]
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rn_valid <= '1;
      for (int r = 0; r < NREG; r++) rn_tag[r] <= '0;
    end else if (flush) begin
      rn_valid <= '1;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (clr_en && clr_reg == RW'(r) && rn_tag[r] == clr_tag)
          rn_valid[r] <= 1'b1;
        if (set_en && set_reg == RW'(r)) begin
          rn_valid[r] <= 1'b0;
          rn_tag[r]   <= set_tag;
        end
      end
    end
  end

  AST_FLUSH_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (&rn_valid)); // R9
  AST_RENAME_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !flush) |=> (!rn_valid[$past(set_reg)] && rn_tag[$past(set_reg)] == $past(set_tag))); // R8
endmodule

// File: rtl/rr_oldest_pick.sv
module rr_oldest_pick #(
  parameter int DEPTH = 8,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] elig,
  input  logic [TW-1:0]    start,
  output logic             found,
  output logic [TW-1:0]    idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (elig[start + TW'(k)]) begin
        found = 1'b1;
        idx   = start + TW'(k);
      end
    end
  end
endmodule

// File: rtl/rob_rename.sv
module rob_rename
  import rr_pkg::*;
#(
  parameter int DEPTH = RR_DEPTH,
  parameter int NREG  = RR_NREG,
  parameter int DW    = RR_DW,
  parameter int OPW   = RR_OPW,
  localparam int TW   = $clog2(DEPTH),
  localparam int PW   = TW + 1,
  localparam int RW   = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           disp_valid,
  output logic           disp_ready,
  input  logic [OPW-1:0] disp_op,
  input  logic [RW-1:0]  disp_src_a,
  input  logic [RW-1:0]  disp_src_b,
  input  logic [RW-1:0]  disp_dst,
  output logic           iss_valid,
  input  logic           iss_ready,
  output logic [TW-1:0]  iss_tag,
  output logic [OPW-1:0] iss_op,
  output logic [DW-1:0]  iss_opnd_a,
  output logic [DW-1:0]  iss_opnd_b,
  input  logic           res_valid,
  input  logic [TW-1:0]  res_tag,
  input  logic [DW-1:0]  res_value,
  output logic           ret_valid,
  output logic [RW-1:0]  ret_reg,
  output logic [DW-1:0]  ret_value
);
  // slot storage
  logic [DEPTH-1:0] e_vld, e_done, e_iss, e_av, e_bv;
  logic [OPW-1:0]   e_op   [DEPTH];
  logic [RW-1:0]    e_dst  [DEPTH];
  logic [DW-1:0]    e_res  [DEPTH];
  logic [DW-1:0]    e_aval [DEPTH];
  logic [DW-1:0]    e_bval [DEPTH];
  logic [TW-1:0]    e_atag [DEPTH];
  logic [TW-1:0]    e_btag [DEPTH];
  logic [DW-1:0]    arch   [NREG];

  logic [PW-1:0] head, tail, count;
  logic [TW-1:0] hidx, tidx;
  logic          disp_fire, iss_fire, ret_fire;

  logic [NREG-1:0] rn_valid;
  logic [TW-1:0]   rn_tag [NREG];

  assign count      = tail - head;
  assign hidx       = head[TW-1:0];
  assign tidx       = tail[TW-1:0];
  assign disp_ready = (count != PW'(DEPTH)) && !flush;
  assign disp_fire  = disp_valid && disp_ready;

  assign ret_valid  = e_vld[hidx] && e_done[hidx] && !flush;
  assign ret_reg    = e_dst[hidx];
  assign ret_value  = e_res[hidx];
  assign ret_fire   = ret_valid;

  rr_rename_table #(.NREG(NREG), .TW(TW)) u_rename (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .set_en   (disp_fire),
    .set_reg  (disp_dst),
    .set_tag  (tidx),
    .clr_en   (ret_fire),
    .clr_reg  (ret_reg),
    .clr_tag  (hidx),
    .rn_valid (rn_valid),
    .rn_tag   (rn_tag)
  );

  // source resolution, one resolver per operand
  logic [RW-1:0] src_id [2];
  logic [1:0]    op_ok;
  logic [DW-1:0] op_val [2];
  logic [TW-1:0] op_tag [2];
  assign src_id[0] = disp_src_a;
  assign src_id[1] = disp_src_b;

  for (genvar s = 0; s < 2; s++) begin : g_src
    rr_src_resolve #(.DW(DW), .TW(TW)) u_res (
      .rn_ok     (rn_valid[src_id[s]]),
      .rn_tag    (rn_tag[src_id[s]]),
      .arch_val  (arch[src_id[s]]),
      .prod_done (e_done[rn_tag[src_id[s]]]),
      .prod_res  (e_res[rn_tag[src_id[s]]]),
      .bus_valid (res_valid),
      .bus_tag   (res_tag),
      .bus_value (res_value),
      .op_ok     (op_ok[s]),
      .op_val    (op_val[s]),
      .op_tag    (op_tag[s])
    );
  end

  // issue selection
  logic [DEPTH-1:0] elig;
  logic             pick_ok;
  logic [TW-1:0]    pick_idx;
  assign elig = e_vld & ~e_iss & e_av & e_bv;

  rr_oldest_pick #(.DEPTH(DEPTH)) u_pick (
    .elig  (elig),
    .start (hidx),
    .found (pick_ok),
    .idx   (pick_idx)
  );

  assign iss_valid  = pick_ok && !flush;
  assign iss_tag    = pick_idx;
  assign iss_op     = e_op[pick_idx];
  assign iss_opnd_a = e_aval[pick_idx];
  assign iss_opnd_b = e_bval[pick_idx];
  assign iss_fire   = iss_valid && iss_ready;

  // pointers and architectural file
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      for (int r = 0; r < NREG; r++) arch[r] <= '0;
    end else if (flush) begin
      tail <= head;
    end else begin
      if (disp_fire) tail <= tail + 1'b1;
      if (ret_fire) begin
        head          <= head + 1'b1;
        arch[ret_reg] <= ret_value;
      end
    end
  end

  // slot state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld <= '0; e_done <= '0; e_iss <= '0; e_av <= '0; e_bv <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_op[i] <= '0; e_dst[i] <= '0; e_res[i] <= '0;
        e_aval[i] <= '0; e_bval[i] <= '0; e_atag[i] <= '0; e_btag[i] <= '0;
      end
    end else if (flush) begin
      e_vld <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (res_valid && e_vld[i]) begin
          if (res_tag == TW'(i)) begin
            e_done[i] <= 1'b1;
            e_res[i]  <= res_value;
          end
          if (!e_av[i] && e_atag[i] == res_tag) begin
            e_av[i]   <= 1'b1;
            e_aval[i] <= res_value;
          end
          if (!e_bv[i] && e_btag[i] == res_tag) begin
            e_bv[i]   <= 1'b1;
            e_bval[i] <= res_value;
          end
        end
        if (iss_fire && iss_tag == TW'(i)) e_iss[i] <= 1'b1;
        if (ret_fire && hidx == TW'(i))    e_vld[i] <= 1'b0;
        if (disp_fire && tidx == TW'(i)) begin
          e_vld[i]  <= 1'b1;
          e_done[i] <= 1'b0;
          e_iss[i]  <= 1'b0;
          e_op[i]   <= disp_op;
          e_dst[i]  <= disp_dst;
          e_av[i]   <= op_ok[0];
          e_aval[i] <= op_val[0];
          e_atag[i] <= op_tag[0];
          e_bv[i]   <= op_ok[1];
          e_bval[i] <= op_val[1];
          e_btag[i] <= op_tag[1];
        end
      end
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PW'(DEPTH)); // R2
  AST_DISP_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> (count != '0)); // R2
  AST_ISSUE_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (e_vld[iss_tag] && e_av[iss_tag] && e_bv[iss_tag] && !e_iss[iss_tag])); // R5
  AST_ISSUE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_fire && !flush) |=> (e_iss[$past(iss_tag)] || !e_vld[$past(iss_tag)])); // R5
  AST_RESULT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !flush) |-> (e_vld[res_tag] && e_iss[res_tag])); // R6
  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> (head == $past(head) + 1'b1)); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (head == tail)); // R9

  for (genvar r = 0; r < NREG; r++) begin : g_inv
    AST_RENAME_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !rn_valid[r] |-> (e_vld[rn_tag[r]]
                        && ({1'b0, TW'(rn_tag[r] - hidx)} < count)
                        && e_dst[rn_tag[r]] == RW'(r))); // R10
  end
endmodule

// File: tb/rob_rename_tb.sv
`timescale 1ns/1ps
module rob_rename_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        disp_valid = 1'b0, disp_ready;
  logic [3:0]  disp_op = '0;
  logic [2:0]  disp_src_a = '0, disp_src_b = '0, disp_dst = '0;
  logic        iss_valid, iss_ready = 1'b0;
  logic [2:0]  iss_tag;
  logic [3:0]  iss_op;
  logic [15:0] iss_opnd_a, iss_opnd_b;
  logic        res_valid = 1'b0;
  logic [2:0]  res_tag = '0;
  logic [15:0] res_value = '0;
  logic        ret_valid;
  logic [2:0]  ret_reg;
  logic [15:0] ret_value;

  always #4 clk = ~clk;

  rob_rename u_dut (.*);

  int total = 0, bad = 0;
  logic [15:0] spec [8], comm [8];
  int          exp_dst [8];
  logic [3:0]  exp_op [8];
  logic [15:0] exp_a [8], exp_b [8], exp_r [8];
  int          bhead = 0, btail = 0;
  int          ptag [8];
  logic [15:0] pval [8];
  int          npend = 0;
  int          res_pct = 50;
  bit          res_en = 1'b1;
  bit          last_iss, last_ret;
  int          last_tag, last_disp_tag;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [15:0] alu_f(logic [3:0] op, logic [15:0] a, logic [15:0] b);
    case (op[1:0])
      2'd0:    return a + b;
      2'd1:    return a - b;
      2'd2:    return a ^ b;
      default: return a + (b << 1);
    endcase
  endfunction

  task automatic cycle(input bit dv, input logic [3:0] op, input logic [2:0] sa,
                       input logic [2:0] sb, input logic [2:0] d, input bit ir, input bit fl);
    @(negedge clk);
    res_valid = 1'b0; res_tag = '0; res_value = '0;
    if (!fl && res_en && npend > 0 && int'($urandom % 100) < res_pct) begin
      int p;
      p = int'($urandom % npend);
      res_valid = 1'b1; res_tag = 3'(ptag[p]); res_value = pval[p];
      ptag[p] = ptag[npend-1]; pval[p] = pval[npend-1]; npend--;
    end
    disp_valid = dv; disp_op = op; disp_src_a = sa; disp_src_b = sb; disp_dst = d;
    iss_ready = ir; flush = fl;
    #1;
    chk(disp_ready == ((btail - bhead) < 8 && !fl), "R2 disp_ready", int'(disp_ready),
        int'((btail - bhead) < 8 && !fl));
    last_iss = 1'b0; last_ret = ret_valid;
    if (ret_valid) begin
      int t;
      t = bhead % 8;
      chk(int'(ret_reg) == exp_dst[t], "R7 ret_reg", int'(ret_reg), exp_dst[t]);
      chk(ret_value == exp_r[t], "R7 R8 ret_value", int'(ret_value), int'(exp_r[t]));
      comm[exp_dst[t]] = exp_r[t];
      bhead++;
    end
    if (iss_valid && iss_ready) begin
      int t;
      t = int'(iss_tag);
      chk(iss_op == exp_op[t], "R5 iss_op", int'(iss_op), int'(exp_op[t]));
      chk(iss_opnd_a == exp_a[t], "R3 R4 R8 R9 operand a", int'(iss_opnd_a), int'(exp_a[t]));
      chk(iss_opnd_b == exp_b[t], "R3 R4 R8 R9 operand b", int'(iss_opnd_b), int'(exp_b[t]));
      ptag[npend] = t; pval[npend] = alu_f(iss_op, iss_opnd_a, iss_opnd_b); npend++;
      last_iss = 1'b1; last_tag = t;
    end
    if (dv && disp_ready) begin
      int t;
      t = btail % 8;
      exp_dst[t] = int'(d); exp_op[t] = op;
      exp_a[t] = spec[sa]; exp_b[t] = spec[sb];
      exp_r[t] = alu_f(op, spec[sa], spec[sb]);
      spec[d] = exp_r[t];
      last_disp_tag = t; btail++;
    end
    if (fl) begin
      chk(!iss_valid && !ret_valid, "R9 quiet during flush", int'(iss_valid || ret_valid), 0);
      for (int r = 0; r < 8; r++) spec[r] = comm[r];
      btail = bhead; npend = 0;
    end
  endtask

  task automatic drain();
    while (btail != bhead) cycle(1'b0, 4'd0, 3'd0, 3'd0, 3'd0, 1'b1, 1'b0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int ta, tc;
    void'($urandom(32'd2024));
    for (int r = 0; r < 8; r++) begin spec[r] = '0; comm[r] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(disp_ready == 1'b1, "R1 disp_ready after reset", int'(disp_ready), 1);
    chk(iss_valid == 1'b0, "R1 iss_valid after reset", int'(iss_valid), 0);
    chk(ret_valid == 1'b0, "R1 ret_valid after reset", int'(ret_valid), 0);
    // R1 R3: registers read as zero from the architectural file
    cycle(1'b1, 4'd0, 3'd3, 3'd5, 3'd0, 1'b1, 1'b0);
    drain();

    // R5: oldest eligible first, a waiting entry is skipped, no repeat
    res_en = 1'b0;
    cycle(1'b1, 4'd0, 3'd2, 3'd3, 3'd1, 1'b0, 1'b0); ta = last_disp_tag;
    cycle(1'b1, 4'd1, 3'd1, 3'd1, 3'd4, 1'b0, 1'b0);
    cycle(1'b1, 4'd2, 3'd6, 3'd7, 3'd5, 1'b0, 1'b0); tc = last_disp_tag;
    cycle(1'b0, 4'd0, 3'd0, 3'd0, 3'd0, 1'b1, 1'b0);
    chk(last_iss && last_tag == ta, "R5 oldest issued first", last_tag, ta);
    cycle(1'b0, 4'd0, 3'd0, 3'd0, 3'd0, 1'b1, 1'b0);
    chk(last_iss && last_tag == tc, "R5 waiting entry skipped", last_tag, tc);
    cycle(1'b0, 4'd0, 3'd0, 3'd0, 3'd0, 1'b1, 1'b0);
    chk(!last_iss, "R5 nothing issued twice", int'(last_iss), 0);
    res_en = 1'b1; drain();

    // R4: consumer dispatched in the cycle the producer result is on the bus
    res_en = 1'b0;
    cycle(1'b1, 4'd3, 3'd1, 3'd4, 3'd6, 1'b0, 1'b0);
    cycle(1'b0, 4'd0, 3'd0, 3'd0, 3'd0, 1'b1, 1'b0);
    res_en = 1'b1; res_pct = 100;
    cycle(1'b1, 4'd0, 3'd6, 3'd6, 3'd7, 1'b0, 1'b0);
    chk(res_valid == 1'b1, "R4 bypass stimulus present", int'(res_valid), 1);
    res_pct = 50; drain();

    // R8: older writer retires while a younger writer of r2 is in flight
    res_en = 1'b0;
    cycle(1'b1, 4'd1, 3'd5, 3'd6, 3'd2, 1'b0, 1'b0);
    cycle(1'b1, 4'd2, 3'd7, 3'd1, 3'd2, 1'b0, 1'b0);
    cycle(1'b0, 4'd0, 3'd0, 3'd0, 3'd0, 1'b1, 1'b0);
    res_en = 1'b1; res_pct = 100;
    cycle(1'b0, 4'd0, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0);
    res_en = 1'b0;
    cycle(1'b0, 4'd0, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0);
    chk(last_ret, "R8 older writer retired", int'(last_ret), 1);
    cycle(1'b1, 4'd0, 3'd2, 3'd2, 3'd3, 1'b0, 1'b0);
    res_en = 1'b1; res_pct = 50; drain();

    // R9: flush discards in-flight work, architectural values survive
    res_en = 1'b0;
    cycle(1'b1, 4'd0, 3'd1, 3'd2, 3'd4, 1'b0, 1'b0);
    cycle(1'b1, 4'd1, 3'd4, 3'd2, 3'd5, 1'b0, 1'b0);
    cycle(1'b1, 4'd2, 3'd0, 3'd0, 3'd0, 1'b1, 1'b1);
    cycle(1'b0, 4'd0, 3'd0, 3'd0, 3'd0, 1'b1, 1'b0);
    chk(!last_iss && !last_ret, "R9 empty after flush", int'(last_iss || last_ret), 0);
    cycle(1'b1, 4'd0, 3'd4, 3'd5, 3'd6, 1'b1, 1'b0);
    res_en = 1'b1; drain();

    // R2 full buffer: fill with ALU held off
    res_en = 1'b0;
    for (int n = 0; n < 10; n++) cycle(1'b1, 4'(n), 3'(n), 3'(n + 1), 3'(n + 2), 1'b0, 1'b0);
    chk((btail - bhead) == 8, "R2 fills to eight", btail - bhead, 8);
    res_en = 1'b1; drain();

    // random traffic with occasional flush
    for (int n = 0; n < 6000; n++)
      cycle(($urandom % 100) < 60, 4'($urandom), 3'($urandom), 3'($urandom), 3'($urandom),
            ($urandom % 4) != 0, ($urandom % 250) == 0);
    drain();
    finish_run();
  end
endmodule